// File: doc/BRIEF.md
# Byte Scan Sequencer with Cascade Handoff

This block reads out a 40-bit captured word one byte at a time on a shared 8-bit bus. A position counter picks which byte is shown. The counter moves forward on each falling edge of an external scan strobe, but only while the active-low enable input is low. Each high phase of the strobe means "put the next byte on the bus". While the strobe is high and the block is enabled, the bus carries the selected byte and the output-enable is high. At all other times the bus drives zero and the output-enable is low.

The five data positions run from the least significant byte to the most significant byte. The first position holds the external prescaler byte, and the next four hold counter bytes 0 to 3. After the fifth counted falling edge the counter enters a sixth, terminal position and stays there. In that position the bus is switched off and the cascade-enable output goes low. Cascade-enable can drive the enable input of a second identical device that shares the same strobe and scan reset. That device then continues the byte stream on the same bus.

The strobe and enable inputs are resynchronised to the system clock. The scan reset is sampled synchronously. A falling strobe edge that arrives while enable is high is dropped; it is not held for later.

Top module: `scan_byte_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block returns to the first byte position and drives bus_oe_o low, bus_o zero and casc_en_o high.
- R2: A low level on scan_rst_n_i at a clock edge puts the block back in the first byte position and raises casc_en_o, from any position including the terminal one.
- R3: Each falling edge of scan_i seen while en_n_i is low advances the position by exactly one. A falling edge seen while en_n_i is high is discarded and is not counted later.
- R4: Byte order: position 1 shows cap_word_i[7:0] (the prescaler byte), and positions 2 to 5 show cap_word_i[15:8], [23:16], [31:24] and [39:32].
- R5: After the fifth counted falling edge the block is in the terminal position. Further strobe edges have no effect, and bus_oe_o stays low even while scan_i is high.
- R6: bus_oe_o is low and bus_o is zero whenever scan_i is low, en_n_i is high, or the block is in the terminal position.
- R7: While scan_i is high, en_n_i is low and the position is not terminal, bus_oe_o is high and bus_o carries the selected byte of the present cap_word_i. It follows changes of that word.
- R8: casc_en_o goes low when the terminal position is reached and stays low until a scan reset.
- R9: When casc_en_o of one device drives en_n_i of a second device and both share scan_i and scan_rst_n_i, the second device's five bytes follow the first device's five bytes, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_i | input | 1 | Scan strobe, asynchronous; its falling edge advances the position, and its high level opens the bus |
| en_n_i | input | 1 | Active-low enable, asynchronous |
| scan_rst_n_i | input | 1 | Active-low scan reset, synchronous to clk |
| cap_word_i | input | 40 | Captured word, prescaler byte in the low 8 bits |
| bus_o | output | 8 | Selected byte, or zero when disabled |
| bus_oe_o | output | 1 | High while bus_o carries valid data |
| casc_en_o | output | 1 | High until the terminal position; low hands the bus to the next device |

## Verification
The assertions assume that each level of scan_i and en_n_i lasts longer than the synchroniser delay, so that every edge is seen exactly once. They also assume that en_n_i changes only while scan_i is low, and that scan_rst_n_i is synchronous and applied while the strobe is low. The stimulus holds every level for six clock cycles, changes the enable only during the low phase of the strobe, and pulses the scan reset for three cycles with the strobe low. With these limits the chained second device sees its enable fall only after the first device's last falling edge, so the handoff is checked without races.

// File: rtl/scan_seq_pkg.sv
// Shared constants for the byte scan sequencer.
// Assumes: byte width and number of bytes fixed per chip; sync depth >= 2.
package scan_seq_pkg;
    localparam int SEQ_BYTE_W      = 8;
    localparam int SEQ_NUM_BYTES   = 5;
    localparam int SEQ_SYNC_STAGES = 2;
endpackage

// File: rtl/scan_sync.sv
// Multi-flop resynchroniser for one asynchronous level input.
// Assumes: STAGES >= 2; the input level is held longer than STAGES clocks.
module scan_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // first stage samples the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d_i;
    end

    // remaining stages built by generate so the depth is a parameter
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/scan_state_ctr.sv
// Position counter: 0..NUM_BYTES-1 select bytes, NUM_BYTES is terminal.
// Assumes: step_i is a one-cycle pulse per strobe falling edge; en_n_i is synchronised.
module scan_state_ctr #(
    parameter int NUM_BYTES = 5,
    parameter int ST_W      = $clog2(NUM_BYTES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            srst_n_i,
    input  logic            step_i,
    input  logic            en_n_i,
    output logic [ST_W-1:0] state_o,
    output logic            term_o
);
    localparam logic [ST_W-1:0] TERM_POS = ST_W'(NUM_BYTES);

    logic [ST_W-1:0] state;
    logic            adv;

    // an edge counts only when enabled and not already terminal
    assign adv    = step_i && !en_n_i && (state != TERM_POS);
    assign term_o = (state == TERM_POS);
    assign state_o = state;

    // position register: reset, scan reset, or single step
    always_ff @(posedge clk) begin
        if (!rst_n)         state <= '0;
        else if (!srst_n_i) state <= '0;
        else if (adv)       state <= state + ST_W'(1);
    end

    p_srst_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_n_i |=> (state_o == '0));

    p_en_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_n_i && en_n_i) |=> $stable(state_o));

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        srst_n_i |=> ((state_o == $past(state_o)) || (state_o == $past(state_o) + ST_W'(1))));

    p_hold_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (term_o && srst_n_i) |=> term_o);
endmodule

// File: rtl/scan_byte_out.sv
// Byte selector and output gating for the shared bus.
// Assumes: state_i is within 0..NUM_BYTES; inputs are synchronised.
module scan_byte_out #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 5,
    parameter int ST_W      = $clog2(NUM_BYTES + 1),
    localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ST_W-1:0]   state_i,
    input  logic              term_i,
    input  logic              scan_s_i,
    input  logic              en_n_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [BYTE_W-1:0] bus_o,
    output logic              oe_o
);
    logic [BYTE_W-1:0] lane [NUM_BYTES];
    logic [BYTE_W-1:0] pick;

    // split the word into byte lanes, least significant first
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    // choose the lane matching the current position
    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (state_i == ST_W'(i)) pick = lane[i];
        end
    end

    // drive only during strobe high, enabled, non-terminal
    always_comb begin
        oe_o  = scan_s_i && !en_n_i && !term_i;
        bus_o = oe_o ? pick : '0;
    end

    p_bus_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> (bus_o == '0));
endmodule

// File: rtl/scan_byte_seq.sv
// Top: byte scan sequencer with cascade handoff.
// Assumes: scan_i/en_n_i levels outlast the sync delay; scan_rst_n_i is synchronous.
module scan_byte_seq
    import scan_seq_pkg::*;
#(
    parameter int BYTE_W      = SEQ_BYTE_W,
    parameter int NUM_BYTES   = SEQ_NUM_BYTES,
    parameter int SYNC_STAGES = SEQ_SYNC_STAGES,
    localparam int WORD_W     = BYTE_W * NUM_BYTES,
    localparam int ST_W       = $clog2(NUM_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_i,
    input  logic              en_n_i,
    input  logic              scan_rst_n_i,
    input  logic [WORD_W-1:0] cap_word_i,
    output logic [BYTE_W-1:0] bus_o,
    output logic              bus_oe_o,
    output logic              casc_en_o
);
    logic            scan_s;
    logic            scan_d;
    logic            en_n_s;
    logic            scan_fall;
    logic [ST_W-1:0] state;
    logic            term;

    scan_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_scan (
        .clk(clk), .rst_n(rst_n), .d_i(scan_i), .q_o(scan_s));

    scan_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
        .clk(clk), .rst_n(rst_n), .d_i(en_n_i), .q_o(en_n_s));

    // previous synchronised strobe, for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) scan_d <= 1'b0;
        else        scan_d <= scan_s;
    end

    assign scan_fall = scan_d && !scan_s;

    scan_state_ctr #(.NUM_BYTES(NUM_BYTES), .ST_W(ST_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .srst_n_i(scan_rst_n_i),
        .step_i(scan_fall), .en_n_i(en_n_s),
        .state_o(state), .term_o(term));

    scan_byte_out #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ST_W(ST_W)) u_out (
        .clk(clk), .rst_n(rst_n), .state_i(state), .term_i(term),
        .scan_s_i(scan_s), .en_n_i(en_n_s), .word_i(cap_word_i),
        .bus_o(bus_o), .oe_o(bus_oe_o));

    // hand the bus on once the terminal position is reached
    assign casc_en_o = !term;

    p_casc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!casc_en_o && scan_rst_n_i) |=> !casc_en_o);

    p_term_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !casc_en_o |-> !bus_oe_o);

    p_oe_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> (scan_s && !en_n_s));
endmodule

// File: tb/scan_byte_seq_bench.sv
`timescale 1ns/1ps
module scan_byte_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan = 1'b0;
    logic        en_n = 1'b1;
    logic        srst_n = 1'b1;
    logic [39:0] word_a = '0;
    logic [39:0] word_b = '0;
    logic [7:0]  bus_a, bus_b;
    logic        oe_a, oe_b, casc_a, casc_b;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    scan_byte_seq u_scan_byte_seq (
        .clk(clk), .rst_n(rst_n), .scan_i(scan), .en_n_i(en_n),
        .scan_rst_n_i(srst_n), .cap_word_i(word_a),
        .bus_o(bus_a), .bus_oe_o(oe_a), .casc_en_o(casc_a));

    scan_byte_seq u_scan_byte_seq_b (
        .clk(clk), .rst_n(rst_n), .scan_i(scan), .en_n_i(casc_a),
        .scan_rst_n_i(srst_n), .cap_word_i(word_b),
        .bus_o(bus_b), .bus_oe_o(oe_b), .casc_en_o(casc_b));

    function automatic logic [7:0] byte_of(input logic [39:0] w, input int i);
        return w[i*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic strobe_hi(); scan = 1'b1; settle(); endtask
    task automatic strobe_lo(); scan = 1'b0; settle(); endtask
    task automatic pulse();     strobe_hi(); strobe_lo(); endtask

    task automatic scan_reset();
        srst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 srst_n = 1'b1;
        settle();
    endtask

    // R1: state after synchronous reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 oe", oe_a, 0);
        chk("R1 bus", bus_a, 0);
        chk("R1 casc", casc_a, 1);
        chk("R1 casc second", casc_b, 1);
        rst_n = 1'b1;
        settle();
    endtask

    // R4 R6 R7 R8 R9 R5: full readout of both chained devices
    task automatic t_chain();
        word_a = 40'hA1_B2_C3_D4_E5;
        word_b = 40'h16_27_38_49_5A;
        en_n = 1'b0;
        settle();
        scan_reset();
        for (int i = 0; i < 5; i++) begin
            strobe_hi();
            chk("R7 oe first", oe_a, 1);
            chk("R4 byte first", bus_a, byte_of(word_a, i));
            chk("R9 second idle", oe_b, 0);
            strobe_lo();
            chk("R6 oe low strobe", oe_a, 0);
            chk("R6 bus zero strobe", bus_a, 0);
        end
        chk("R8 casc low", casc_a, 0);
        for (int i = 0; i < 5; i++) begin
            strobe_hi();
            chk("R9 byte second", bus_b, byte_of(word_b, i));
            chk("R9 oe second", oe_b, 1);
            chk("R5 first silent", oe_a, 0);
            chk("R6 first bus zero", bus_a, 0);
            strobe_lo();
        end
        chk("R9 casc second", casc_b, 0);
        pulse();
        strobe_hi();
        chk("R5 terminal oe", oe_a, 0);
        chk("R5 second terminal oe", oe_b, 0);
        strobe_lo();
        chk("R8 casc held", casc_a, 0);
    endtask

    // R2 R3: scan reset from terminal and from the middle
    task automatic t_scan_reset();
        scan_reset();
        chk("R2 casc restored", casc_a, 1);
        chk("R2 casc second", casc_b, 1);
        word_a = 40'h0F_1E_2D_3C_4B;
        for (int i = 0; i < 3; i++) pulse();
        strobe_hi();
        chk("R3 three steps", bus_a, byte_of(word_a, 3));
        strobe_lo();
        scan_reset();
        strobe_hi();
        chk("R2 home byte", bus_a, byte_of(word_a, 0));
        strobe_lo();
    endtask

    // R3 R6: edges while disabled are discarded
    task automatic t_enable_gate();
        scan_reset();
        en_n = 1'b1;
        settle();
        strobe_hi();
        chk("R6 disabled oe", oe_a, 0);
        chk("R6 disabled bus", bus_a, 0);
        strobe_lo();
        pulse();
        en_n = 1'b0;
        settle();
        strobe_hi();
        chk("R3 dropped edges", bus_a, byte_of(word_a, 0));
        strobe_lo();
        en_n = 1'b1;
        settle();
        pulse();
        en_n = 1'b0;
        settle();
        strobe_hi();
        chk("R3 one step only", bus_a, byte_of(word_a, 1));
        strobe_lo();
    endtask

    // R7: bus tracks a changing word while the strobe is high
    task automatic t_live_word();
        scan_reset();
        pulse();
        strobe_hi();
        word_a = 40'h00_00_00_99_00;
        settle();
        chk("R7 live byte", bus_a, 8'h99);
        strobe_lo();
    endtask

    initial begin
        t_reset();
        t_chain();
        t_scan_reset();
        t_enable_gate();
        t_live_word();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule